// File: doc/BRIEF.md
# Comparator-Driven Successive-Approximation ADC Controller

This block sequences analog-to-digital conversions built from an external comparator and a single-bit pulse DAC fed with a digital code. For each conversion it runs a serial binary search: it presents a trial code to the DAC and waits for the external RC filter to settle. It then reads the comparator, which reports whether the analog input lies above the filtered DAC voltage, and keeps or clears the trial bit. The DAC code is one bit wider than the result. Once every bit is decided, the upper bits of the trial code become the result.

Each trial code is held for 2^DAC_W x (F+1) clocks, where F is the settle multiplier taken from `fstm_i`. A full conversion therefore takes DAC_W steps plus a single gap cycle. The gap cycle carries a one-cycle push strobe that delivers the result toward a FIFO. While enabled, conversions run back to back. `sample_o` stays high for the whole search, so it can drive an external sample-and-hold. The controller has three states:
- ST_IDLE: waiting for enable.
- ST_TRIAL: the search is running.
- ST_PUSH: the result strobe and gap cycle.

The transitions are:
- idle_to_trial: enable seen in ST_IDLE.
- trial_next_bit: a step ends with bits still left; the state stays ST_TRIAL.
- trial_to_push: the last bit is decided.
- push_to_trial: enable is still high.
- push_to_idle: enable is low.

Top module: `adc_sar_ctrl`

## Requirements
- R1: While reset is held, `sample_o` and `push_o` are 0 and `dac_in_o` and `result_o` are all zeros.
- R2: In the first cycle of every conversion (the cycle `sample_o` rises), `dac_in_o` holds only its most significant bit set (value 2^(DAC_W-1)).
- R3: Each trial code stays on `dac_in_o` for exactly 2^DAC_W x (F+1) cycles. Within a conversion it changes only when a multiple of 2^DAC_W cycles has passed since `sample_o` rose.
- R4: Bits are decided from MSB down to bit 0. At the end of each step, a high comparator level keeps the bit and a low level clears it. The comparator passes through two synchronising flops first. With a comparator that reports "input above code", the final trial code is the largest code below the input, and `result_o` equals that code shifted right by one (its upper DAC_W-1 bits).
- R5: `push_o` is a single-cycle pulse that occurs in the cycle after the last step, with `result_o` valid in that cycle. While enabled, pushes repeat every DAC_W x 2^DAC_W x (F+1) + 1 cycles.
- R6: `sample_o` is high in every cycle of the search. It is low for exactly one cycle (the push cycle) between back-to-back conversions.
- R7: F is captured from `fstm_i` at the clock edge that starts a conversion. Later changes to `fstm_i` do not alter that conversion's timing.
- R8: With `en_i` low, no conversion starts and `sample_o` and `push_o` stay 0. Dropping `en_i` during a conversion lets that conversion finish and push, after which the block idles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run conversions while high |
| fstm_i | input | FSTM_W | Settle multiplier F; a step lasts 2^DAC_W x (F+1) cycles |
| agtr_i | input | 1 | Comparator output, high when the analog input exceeds the DAC voltage (asynchronous) |
| dac_in_o | output | DAC_W | Trial code for the pulse DAC |
| sample_o | output | 1 | High during a conversion; drives an external sample-and-hold |
| result_o | output | DAC_W-1 | Last conversion result |
| push_o | output | 1 | One-cycle strobe: `result_o` is new |

## Verification
The hardest situation to reach is the one where the comparator's decision depends on the very code the controller is currently presenting. A fixed input pattern cannot reproduce that closed loop. The bench therefore models the analog input as an integer level and derives the comparator continuously as "level above `dac_in_o`", which closes the loop through the synchroniser. It then sweeps every level from 0 to 2^DAC_W on a 4-bit DAC while rotating the settle multiplier through all its values. It also scrambles `fstm_i` a few cycles into each conversion, so that a design sampling it late would stretch or shrink the measured step and push period.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_PUSH  = 2'd2
    } ctrl_state_e;

    // Cycles one trial code is held: 2^dac_w * (f + 1).
    function automatic int unsigned step_cycles(int unsigned dac_w, int unsigned f);
        return (32'd1 << dac_w) * (f + 32'd1);
    endfunction

endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[s] <= 1'b0;
                    else       chain_q[s] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[s] <= 1'b0;
                    else       chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_step_timer.sv
module adc_step_timer #(
    parameter int DAC_W  = 9,
    parameter int FSTM_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,   // start of conversion: clear and capture F
    input  logic              run_i,    // count while the search is active
    input  logic [FSTM_W-1:0] fstm_i,
    output logic              last_o    // final cycle of the current step
);
    localparam logic [DAC_W-1:0] SUB_MAX = {DAC_W{1'b1}};

    logic [DAC_W-1:0]  sub_q;
    logic [FSTM_W-1:0] rep_q;
    logic [FSTM_W-1:0] f_q;
    logic              sub_wrap;

    assign sub_wrap = (sub_q == SUB_MAX);
    assign last_o   = run_i && sub_wrap && (rep_q == f_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sub_q <= '0;
            rep_q <= '0;
            f_q   <= '0;
        end else if (load_i) begin
            sub_q <= '0;
            rep_q <= '0;
            f_q   <= fstm_i;
        end else if (run_i) begin
            sub_q <= sub_q + 1'b1;
            if (sub_wrap) begin
                if (rep_q == f_q) rep_q <= '0;
                else              rep_q <= rep_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_trial_reg.sv
module adc_trial_reg #(
    parameter int DAC_W = 9,
    parameter int IDX_W = (DAC_W > 1) ? $clog2(DAC_W) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,    // reset the search to mid-scale
    input  logic             decide_i,  // settle bit idx_i from keep_i
    input  logic [IDX_W-1:0] idx_i,
    input  logic             keep_i,
    output logic [DAC_W-1:0] trial_o,
    output logic [DAC_W-1:0] trial_next_o
);
    logic [DAC_W-1:0] trial_q;

    genvar b;
    generate
        for (b = 0; b < DAC_W; b++) begin : g_bit
            always_comb begin
                if (load_i) begin
                    trial_next_o[b] = (b == DAC_W - 1);
                end else if (decide_i && (int'(idx_i) == b)) begin
                    trial_next_o[b] = keep_i;
                end else if (decide_i && (int'(idx_i) == b + 1)) begin
                    trial_next_o[b] = 1'b1;
                end else begin
                    trial_next_o[b] = trial_q[b];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) trial_q <= '0;
        else       trial_q <= trial_next_o;
    end

    assign trial_o = trial_q;
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
    import adc_sar_pkg::*;
#(
    parameter int DAC_W  = 9,
    parameter int FSTM_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic [FSTM_W-1:0]  fstm_i,
    input  logic               agtr_i,
    output logic [DAC_W-1:0]   dac_in_o,
    output logic               sample_o,
    output logic [DAC_W-2:0]   result_o,
    output logic               push_o
);
    localparam int RES_W = DAC_W - 1;
    localparam int IDX_W = (DAC_W > 1) ? $clog2(DAC_W) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DAC_W - 1);

    ctrl_state_e state_q, state_d;

    logic             agtr_s;
    logic             step_last;
    logic             load;
    logic             run;
    logic             decide;
    logic             final_bit;
    logic [IDX_W-1:0] idx_q;
    logic [DAC_W-1:0] trial;
    logic [DAC_W-1:0] trial_next;
    logic [RES_W-1:0] result_q;

    adc_sync2 #(.STAGES(2)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (agtr_i),
        .q_o   (agtr_s)
    );

    adc_step_timer #(.DAC_W(DAC_W), .FSTM_W(FSTM_W)) u_timer (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .run_i  (run),
        .fstm_i (fstm_i),
        .last_o (step_last)
    );

    adc_trial_reg #(.DAC_W(DAC_W), .IDX_W(IDX_W)) u_trial (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .load_i       (load),
        .decide_i     (decide),
        .idx_i        (idx_q),
        .keep_i       (agtr_s),
        .trial_o      (trial),
        .trial_next_o (trial_next)
    );

    assign final_bit = (idx_q == '0);

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en_i) state_d = ST_TRIAL;                  // idle_to_trial
            ST_TRIAL: if (step_last && final_bit) state_d = ST_PUSH; // trial_to_push
            ST_PUSH:  state_d = en_i ? ST_TRIAL : ST_IDLE;           // push_to_trial / push_to_idle
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and controls per state
    always_comb begin
        sample_o = 1'b0;
        push_o   = 1'b0;
        load     = 1'b0;
        run      = 1'b0;
        decide   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = en_i;
            end
            ST_TRIAL: begin
                sample_o = 1'b1;
                run      = 1'b1;
                decide   = step_last;
            end
            ST_PUSH: begin
                push_o = 1'b1;
                load   = en_i;
            end
            default: begin
                load = 1'b0;
            end
        endcase
    end

    // Bit index walks from the MSB down
    always_ff @(posedge clk_i) begin
        if (rst_i)                        idx_q <= '0;
        else if (load)                    idx_q <= IDX_TOP;
        else if (decide && !final_bit)    idx_q <= idx_q - 1'b1;
    end

    // Result keeps the upper bits of the finished trial code
    always_ff @(posedge clk_i) begin
        if (rst_i)                      result_q <= '0;
        else if (decide && final_bit)   result_q <= trial_next[DAC_W-1:1];
    end

    assign dac_in_o = trial;
    assign result_o = result_q;
endmodule

// File: rtl/adc_sar_ctrl_chk.sv
module adc_sar_ctrl_chk #(
    parameter int DAC_W  = 9,
    parameter int FSTM_W = 4
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             en_i,
    input logic [DAC_W-1:0] dac_in_o,
    input logic             sample_o,
    input logic             push_o
);
    localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

    logic [DAC_W-1:0] phase_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)         phase_q <= '0;
        else if (sample_o) phase_q <= phase_q + 1'b1;
        else               phase_q <= '0;
    end

    // R5
    push_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        push_o |=> !push_o);

    // R6
    push_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        push_o |-> !sample_o);

    // R2
    mid_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sample_o) |-> (dac_in_o == MID));

    // R3
    step_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sample_o && $past(sample_o) && (dac_in_o != $past(dac_in_o))) |-> (phase_q == '0));

    // R8
    stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (push_o && !en_i) |=> (!sample_o && !push_o));

    // R6
    search_end_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sample_o) |-> push_o);
endmodule

bind adc_sar_ctrl adc_sar_ctrl_chk #(.DAC_W(DAC_W), .FSTM_W(FSTM_W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .dac_in_o (dac_in_o),
    .sample_o (sample_o),
    .push_o   (push_o)
);

// File: tb/tb_adc_sar_ctrl.sv
module tb_adc_sar_ctrl;
    localparam int DW    = 4;
    localparam int FW    = 2;
    localparam int RW    = DW - 1;
    localparam int NCONV = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [FW-1:0] fstm = '0;
    logic          agtr;
    logic [DW-1:0] dac;
    logic          sample;
    logic [RW-1:0] result;
    logic          push;

    int vin = 0;
    assign agtr = (vin > int'(dac));

    always #2 clk = ~clk;

    adc_sar_ctrl #(.DAC_W(DW), .FSTM_W(FW)) dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .en_i     (en),
        .fstm_i   (fstm),
        .agtr_i   (agtr),
        .dac_in_o (dac),
        .sample_o (sample),
        .result_o (result),
        .push_o   (push)
    );

    int checks = 0, errors = 0;
    int conv_idx = 0, pushes = 0, cnt = 0, run = 0, low_run = 0, conv_f = 0;
    bit have_prev = 0, prev_sample = 0, finished = 0;
    logic [DW-1:0] prev_dac = '0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_res(int v);
        return (v == 0) ? 0 : ((v - 1) >> 1);
    endfunction

    // Monitor: sample away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (push) begin
                chk(int'(result) == exp_res(vin), "R4 result", int'(result), exp_res(vin));
                if (have_prev)
                    chk(cnt == DW * (1 << DW) * (conv_f + 1) + 1, "R5 R7 push period",
                        cnt, DW * (1 << DW) * (conv_f + 1) + 1);
                pushes++;
                have_prev = 1;
                cnt = 1;
                conv_idx++;
                vin    = conv_idx % ((1 << DW) + 1);
                conv_f = (conv_idx * 3) % (1 << FW);
                fstm   = FW'(conv_f);
            end else begin
                cnt++;
                if (have_prev && cnt == 4) fstm = ~FW'(conv_f); // R7 late change
            end

            if (sample && !prev_sample) begin
                chk(dac == DW'(1 << (DW - 1)), "R2 first trial", int'(dac), 1 << (DW - 1));
                if (have_prev) chk(low_run == 1, "R6 gap length", low_run, 1);
                run = 1;
            end else if (sample && prev_sample) begin
                if (dac != prev_dac) begin
                    chk(run == (1 << DW) * (conv_f + 1), "R3 step length", run, (1 << DW) * (conv_f + 1));
                    run = 1;
                end else begin
                    run++;
                end
            end
            if (!sample) low_run = prev_sample ? 1 : low_run + 1;
            prev_sample = sample;
            prev_dac    = dac;
        end
    end

    initial begin
        int snap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!sample && !push, "R1 reset flags", int'({sample, push}), 0);
        chk(dac == '0 && result == '0, "R1 reset data", int'({dac, result}), 0);
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!sample && !push, "R8 idle disabled", int'({sample, push}), 0);
        end
        vin = 0; conv_f = 0; fstm = '0;
        en = 1'b1;
        while (pushes < NCONV) @(negedge clk);
        repeat (5) @(negedge clk);
        en = 1'b0;
        while (pushes < NCONV + 1) @(negedge clk);
        snap = pushes;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            chk(!sample && pushes == snap, "R8 stop after finish", int'(sample), 0);
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", pushes, NCONV + 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule